// File: doc/BRIEF.md
# Memory-Mapped LPC I/O Cycle Engine

This block bridges a simple register bus to a Low Pin Count link. It is meant for a processor that has no native I/O port space. Software programs a byte count, a command and a 16-bit target port. For writes it also queues the payload bytes. It then triggers a burst. The engine runs one byte-wide I/O cycle per count on the frame strobe and the four-bit multiplexed LAD lines. Across the burst it either holds the port fixed or steps it up by one for each byte.

The target can stretch any cycle with wait SYNC codes, and the engine tolerates a bounded number of them. It aborts the burst if a target stalls too long or returns an error code. Bytes read back are queued for software to drain. Two status bits report the result: one for idle and one for a clean finish. A sticky completion flag, cleared by writing 1, can raise an interrupt.

Register offsets: 0x00 trigger, 0x04 status, 0x08 interrupt control, 0x10 count, 0x14 command, 0x20 port, 0x24 write-data push, 0x28 read-data pop.

Top module: `lpc_io_bridge`

## Requirements
- R1: After reset, status (0x04) reads 1 (idle, not OK), interrupt control (0x08) reads 0, the frame strobe is high, LAD is not driven, and a read of 0x28 returns 0.
- R2: Each byte cycle starts with one clock of frame low and LAD=0000. It is followed by a type nibble (0010 write, 0000 read) and then the 16-bit port, most significant nibble first. A write then sends its data low nibble first, followed by two turnaround clocks and SYNC. A read sends two turnaround clocks, then SYNC, then takes its data low nibble first. Every cycle ends with two more turnaround clocks.
- R3: Command bit 3 set keeps every cycle of a burst on the programmed port. When it is clear, the port rises by one for each byte. Command bit 0 set selects write and clear selects read.
- R4: Bytes pushed at 0x24 are sent in push order. Bytes read from the link are returned at 0x28 in arrival order, one per read, in bits 7:0. A read of 0x28 with nothing queued returns 0.
- R5: Writing 1 to bit 0 of 0x00 launches as many cycles as the count register (0x10) holds. Written values above 16 are stored as 16. A launch with count 0 runs no cycle and leaves the status unchanged.
- R6: SYNC codes 0110 and 0101 stretch a cycle. Up to 256 such wait clocks followed by a ready code (0000) complete the cycle normally.
- R7: A 257th wait clock, or any SYNC code other than ready or wait, aborts the burst. No further cycle starts, status becomes idle with OK clear, and both data queues are emptied.
- R8: Status bit 0 is idle and bit 1 is finished-OK. Both read 0 while a burst runs, and a clean burst leaves both set.
- R9: Bit 1 of 0x08 is set at the end of every burst, clean or aborted, and is cleared by writing 1 to it. Bit 0 is the interrupt enable. The irq output is high only when both bits are set.
- R10: While a burst runs, writes to the count, command, port and trigger registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register bus and the LPC link |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the read queue at 0x28 |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| irq | output | 1 | Completion interrupt |
| lpc_frame_n | output | 1 | Active-low cycle frame strobe |
| lad_out | output | 4 | LAD value driven by the host |
| lad_oe | output | 1 | LAD output enable |
| lad_in | input | 4 | LAD value seen from the target |

## Verification
The bench goes after the exact wait limit. A target that waits 256 clocks must complete, while one that waits longer must abort. An off-by-one counter either kills valid slow cycles or hangs on a dead target. Aborts are checked through the queues: a stale write byte left behind would be sent by the next burst, and a stale read byte would appear at 0x28 instead of 0. Other cases cover count saturation and zero count, and reprogramming during a burst. These show up as a wrong cycle count, or a port or count register that changes mid-burst. Random bursts mix direction, port mode, length and waits, and compare every wire address and data byte against bench-computed values.

// File: rtl/lpc_bridge_pkg.sv
package lpc_bridge_pkg;

    localparam int MAX_BURST = 16;
    localparam int CNT_W     = $clog2(MAX_BURST + 1);
    localparam int MAX_WAIT  = 256;
    localparam int WAIT_W    = $clog2(MAX_WAIT + 1);
    localparam int PORT_W    = 16;

    localparam int OFS_GO   = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_IRQ  = 'h08;
    localparam int OFS_CNT  = 'h10;
    localparam int OFS_CMD  = 'h14;
    localparam int OFS_PORT = 'h20;
    localparam int OFS_WDAT = 'h24;
    localparam int OFS_RDAT = 'h28;

    localparam logic [3:0] NIB_START      = 4'b0000;
    localparam logic [3:0] NIB_READY      = 4'b0000;
    localparam logic [3:0] NIB_WAIT_LONG  = 4'b0110;
    localparam logic [3:0] NIB_WAIT_SHORT = 4'b0101;
    localparam logic [3:0] NIB_PARK       = 4'b1111;

    typedef enum logic [3:0] {
        PH_IDLE, PH_START, PH_CTDIR, PH_ADDR, PH_WDATA,
        PH_TAR, PH_SYNC, PH_RDATA, PH_FTAR
    } phase_t;

    typedef struct packed {
        logic       same_port;
        logic [1:0] kind;
        logic       is_write;
    } cmd_t;

    function automatic logic [CNT_W-1:0] clamp_count(input logic [31:0] v);
        if (v > 32'(MAX_BURST)) return CNT_W'(MAX_BURST);
        return v[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/lpc_byte_fifo.sv
module lpc_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic         flush,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [LVL_W-1:0] lvl;

    wire do_push = push && !full;
    wire do_pop  = pop && !empty;

    assign empty = (lvl == '0);
    assign full  = (lvl == LVL_W'(DEPTH));
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            lvl <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + PTR_W'(1);
            if (do_pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + PTR_W'(1);
            lvl <= lvl + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end
endmodule

// File: rtl/lpc_cycle_seq.sv
module lpc_cycle_seq
    import lpc_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_write,
    input  logic              cfg_same,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic [7:0]        wbyte,
    output logic              wpop,
    output logic              rpush,
    output logic [7:0]        rbyte,
    output logic              busy,
    output logic              done,
    output logic              abort,
    output logic              lframe_n,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [3:0]        lad_in
);
    phase_t              ph;
    logic [1:0]          nib;
    logic [CNT_W-1:0]    left;
    logic [PORT_W-1:0]   port;
    logic                wr_q, same_q;
    logic [WAIT_W-1:0]   waits;
    logic [3:0]          lo_q;

    wire sync_ready = (lad_in == NIB_READY);
    wire sync_wait  = (lad_in == NIB_WAIT_LONG) || (lad_in == NIB_WAIT_SHORT);
    wire may_wait   = sync_wait && (waits < WAIT_W'(MAX_WAIT));
    wire last_byte  = (left == CNT_W'(1));

    assign busy  = (ph != PH_IDLE);
    assign abort = (ph == PH_SYNC) && !sync_ready && !may_wait;
    assign done  = abort || ((ph == PH_FTAR) && nib[0] && last_byte);
    assign wpop  = (ph == PH_WDATA) && nib[0];
    assign rpush = (ph == PH_RDATA) && nib[0];
    assign rbyte = {lad_in, lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            nib    <= '0;
            left   <= '0;
            port   <= '0;
            wr_q   <= 1'b0;
            same_q <= 1'b0;
            waits  <= '0;
            lo_q   <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (go && cfg_count != '0) begin
                    ph     <= PH_START;
                    left   <= cfg_count;
                    port   <= cfg_port;
                    wr_q   <= cfg_write;
                    same_q <= cfg_same;
                end
                PH_START: ph <= PH_CTDIR;
                PH_CTDIR: begin
                    ph  <= PH_ADDR;
                    nib <= '0;
                end
                PH_ADDR: if (nib == 2'd3) begin
                    nib <= '0;
                    ph  <= wr_q ? PH_WDATA : PH_TAR;
                end else nib <= nib + 2'd1;
                PH_WDATA: if (nib[0]) begin
                    nib <= '0;
                    ph  <= PH_TAR;
                end else nib <= nib + 2'd1;
                PH_TAR: if (nib[0]) begin
                    nib   <= '0;
                    waits <= '0;
                    ph    <= PH_SYNC;
                end else nib <= nib + 2'd1;
                PH_SYNC: begin
                    if (sync_ready)    ph <= wr_q ? PH_FTAR : PH_RDATA;
                    else if (may_wait) waits <= waits + WAIT_W'(1);
                    else               ph <= PH_IDLE;
                end
                PH_RDATA: if (nib[0]) begin
                    nib <= '0;
                    ph  <= PH_FTAR;
                end else begin
                    lo_q <= lad_in;
                    nib  <= nib + 2'd1;
                end
                PH_FTAR: if (nib[0]) begin
                    nib <= '0;
                    if (last_byte) ph <= PH_IDLE;
                    else begin
                        left <= left - CNT_W'(1);
                        port <= same_q ? port : port + PORT_W'(1);
                        ph   <= PH_START;
                    end
                end else nib <= nib + 2'd1;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        lframe_n = 1'b1;
        lad_oe   = 1'b0;
        lad_out  = NIB_PARK;
        case (ph)
            PH_START: begin
                lframe_n = 1'b0;
                lad_oe   = 1'b1;
                lad_out  = NIB_START;
            end
            PH_CTDIR: begin
                lad_oe  = 1'b1;
                lad_out = {2'b00, wr_q, 1'b0};
            end
            PH_ADDR: begin
                lad_oe  = 1'b1;
                lad_out = port[{~nib, 2'b00} +: 4];
            end
            PH_WDATA: begin
                lad_oe  = 1'b1;
                lad_out = nib[0] ? wbyte[7:4] : wbyte[3:0];
            end
            PH_TAR: lad_oe = !nib[0];
            default: ;
        endcase
    end
endmodule

// File: rtl/lpc_io_bridge.sv
module lpc_io_bridge
    import lpc_bridge_pkg::*;
#(
    parameter int FIFO_DEPTH = MAX_BURST,
    parameter int REG_AW     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              lpc_frame_n,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [3:0]        lad_in
);
    logic [CNT_W-1:0]  cnt_q;
    cmd_t              cmd_q;
    logic [PORT_W-1:0] addr_q;
    logic              irq_en_q, irq_flag_q, stat_ok_q;

    logic       busy, seq_done, seq_abort, wpop, rpush;
    logic [7:0] wbyte, rbyte, rd_dout;
    logic       rd_empty, wr_empty, rd_full_unused, wr_full_unused;

    wire sel_go   = (reg_addr == REG_AW'(OFS_GO));
    wire sel_stat = (reg_addr == REG_AW'(OFS_STAT));
    wire sel_irq  = (reg_addr == REG_AW'(OFS_IRQ));
    wire sel_cnt  = (reg_addr == REG_AW'(OFS_CNT));
    wire sel_cmd  = (reg_addr == REG_AW'(OFS_CMD));
    wire sel_port = (reg_addr == REG_AW'(OFS_PORT));
    wire sel_wdat = (reg_addr == REG_AW'(OFS_WDAT));
    wire sel_rdat = (reg_addr == REG_AW'(OFS_RDAT));

    wire go = reg_wr && sel_go && reg_wdata[0] && !busy && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            cmd_q      <= '0;
            addr_q     <= '0;
            irq_en_q   <= 1'b0;
            irq_flag_q <= 1'b0;
            stat_ok_q  <= 1'b0;
        end else begin
            if (reg_wr && !busy) begin
                if (sel_cnt)  cnt_q  <= clamp_count(reg_wdata);
                if (sel_cmd)  cmd_q  <= cmd_t'(reg_wdata[3:0]);
                if (sel_port) addr_q <= reg_wdata[PORT_W-1:0];
            end
            if (reg_wr && sel_irq) begin
                irq_en_q <= reg_wdata[0];
                if (reg_wdata[1]) irq_flag_q <= 1'b0;
            end
            if (seq_done) irq_flag_q <= 1'b1;
            if (go)            stat_ok_q <= 1'b0;
            else if (seq_done) stat_ok_q <= !seq_abort;
        end
    end

    assign irq = irq_en_q && irq_flag_q;

    always_comb begin
        reg_rdata = '0;
        if (sel_stat)      reg_rdata = {30'd0, stat_ok_q, !busy};
        else if (sel_irq)  reg_rdata = {30'd0, irq_flag_q, irq_en_q};
        else if (sel_cnt)  reg_rdata = 32'(cnt_q);
        else if (sel_cmd)  reg_rdata = {28'd0, cmd_q};
        else if (sel_port) reg_rdata = 32'(addr_q);
        else if (sel_rdat) reg_rdata = rd_empty ? 32'd0 : {24'd0, rd_dout};
    end

    lpc_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) wr_fifo_i (
        .clk(clk), .rst(rst),
        .push(reg_wr && sel_wdat), .pop(wpop), .flush(seq_abort),
        .din(reg_wdata[7:0]), .dout(wbyte),
        .empty(wr_empty), .full(wr_full_unused)
    );

    lpc_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) rd_fifo_i (
        .clk(clk), .rst(rst),
        .push(rpush), .pop(reg_rd && sel_rdat), .flush(seq_abort),
        .din(rbyte), .dout(rd_dout),
        .empty(rd_empty), .full(rd_full_unused)
    );

    lpc_cycle_seq seq_i (
        .clk(clk), .rst(rst), .go(go),
        .cfg_count(cnt_q), .cfg_write(cmd_q.is_write), .cfg_same(cmd_q.same_port),
        .cfg_port(addr_q), .wbyte(wbyte), .wpop(wpop),
        .rpush(rpush), .rbyte(rbyte), .busy(busy),
        .done(seq_done), .abort(seq_abort),
        .lframe_n(lpc_frame_n), .lad_out(lad_out), .lad_oe(lad_oe), .lad_in(lad_in)
    );
endmodule

// File: rtl/lpc_io_bridge_chk.sv
module lpc_io_bridge_chk
    import lpc_bridge_pkg::*;
#(
    parameter int REG_AW = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              lpc_frame_n,
    input logic              lad_oe,
    input logic [3:0]        lad_out,
    input logic              busy,
    input logic              seq_done,
    input logic              seq_abort,
    input logic              irq_flag,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [PORT_W-1:0] port_reg,
    input logic              rd_empty,
    input logic              wr_empty
);
    // R2: the frame strobe carries the start nibble and lasts one clock
    a_r2_start_nibble: assert property (@(posedge clk) disable iff (rst)
        !lpc_frame_n |-> (lad_oe && lad_out == NIB_START));
    a_r2_frame_single: assert property (@(posedge clk) disable iff (rst)
        !lpc_frame_n |=> lpc_frame_n);
    // R7: an abort leaves both queues empty
    a_r7_abort_flush: assert property (@(posedge clk) disable iff (rst)
        seq_abort |=> (rd_empty && wr_empty));
    // R8: the engine is idle after any burst end
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !busy);
    // R9: every burst end leaves the completion flag set
    a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> irq_flag);
    // R10: port register holds while a burst runs
    a_r10_port_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr == REG_AW'(OFS_PORT)) |=> $stable(port_reg));
endmodule

bind lpc_io_bridge lpc_io_bridge_chk #(.REG_AW(REG_AW)) chk_i (
    .clk(clk), .rst(rst), .lpc_frame_n(lpc_frame_n), .lad_oe(lad_oe),
    .lad_out(lad_out), .busy(busy), .seq_done(seq_done), .seq_abort(seq_abort),
    .irq_flag(irq_flag_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .port_reg(addr_q), .rd_empty(rd_empty), .wr_empty(wr_empty)
);

// File: tb/lpc_io_bridge_tb_top.sv
module lpc_io_bridge_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, lpc_frame_n, lad_oe;
    logic [3:0]  lad_out;
    logic [3:0]  lad_in = 4'hF;

    lpc_io_bridge dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .lpc_frame_n(lpc_frame_n), .lad_out(lad_out), .lad_oe(lad_oe), .lad_in(lad_in)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    int k, s_at, nstart = 0, ncyc = 0, nwait_cfg = 0;
    bit active = 0, mdir = 0, err_cfg = 0;
    logic [15:0] maddr;
    logic [7:0]  mwd, mrd;
    logic [15:0] cap_addr [32];
    logic [7:0]  cap_wd [32];
    bit          cap_dir [32];
    logic [7:0]  wq [16];

    function automatic logic [7:0] rd_val(input logic [15:0] a, input int idx);
        return a[7:0] ^ 8'hA5 ^ 8'(idx * 29);
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            active = 0;
            lad_in = 4'hF;
        end else if (!lpc_frame_n) begin
            active = 1; k = 0; nstart++; lad_in = 4'hF;
        end else if (active) begin
            k++;
            lad_in = 4'hF;
            if (k == 1) mdir = lad_out[1];
            if (k >= 2 && k <= 5) maddr = {maddr[11:0], lad_out};
            if (mdir && k == 6) mwd[3:0] = lad_out;
            if (mdir && k == 7) mwd[7:4] = lad_out;
            s_at = mdir ? 10 : 8;
            if (k >= s_at && k < s_at + nwait_cfg) lad_in = (k[0]) ? 4'b0101 : 4'b0110;
            else if (k == s_at + nwait_cfg) begin
                if (err_cfg) begin
                    lad_in = 4'b1010; active = 0;
                end else begin
                    lad_in = 4'b0000;
                    if (ncyc < 32) begin
                        cap_addr[ncyc] = maddr; cap_wd[ncyc] = mwd; cap_dir[ncyc] = mdir;
                    end
                    mrd = rd_val(maddr, ncyc);
                    ncyc++;
                end
            end else if (!mdir && k == s_at + nwait_cfg + 1) lad_in = mrd[3:0];
            else if (!mdir && k == s_at + nwait_cfg + 2) lad_in = mrd[7:4];
        end
    end

    // ---------------- register access ----------------
    task automatic reg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 6'(a);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] st;
        st = 0;
        for (int i = 0; i < 3000 && !st[0]; i++) reg_read('h04, st);
        if (!st[0]) check(req, "burst never went idle", st, 32'h1);
    endtask

    task automatic launch(input bit wr, input bit same, input int cnt_w, input int npush,
                          input logic [15:0] a, input int waits, input bit err);
        nwait_cfg = waits; err_cfg = err; ncyc = 0; nstart = 0;
        for (int i = 0; i < npush; i++) reg_write('h24, 32'(wq[i]));
        reg_write('h10, 32'(cnt_w));
        reg_write('h14, {28'd0, same, 2'b00, wr});
        reg_write('h20, 32'(a));
        reg_write('h00, 32'h1);
    endtask

    task automatic verify(input string req, input bit wr, input bit same, input int cnt, input logic [15:0] a);
        logic [31:0] d;
        logic [15:0] ea;
        check(req, "cycle count", ncyc, cnt);
        for (int i = 0; i < cnt; i++) begin
            ea = same ? a : a + 16'(i);
            check(req, "wire port", cap_addr[i], ea);
            check(req, "wire direction", 32'(cap_dir[i]), 32'(wr));
            if (wr) check(req, "wire data", cap_wd[i], wq[i]);
            else begin
                reg_read('h28, d);
                check(req, "read byte", d, 32'(rd_val(ea, i)));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R1", "frame strobe", 32'(lpc_frame_n), 32'h1);
        check("R1", "lad enable", 32'(lad_oe), 32'h0);
        reg_read('h04, d); check("R1", "status", d, 32'h1);
        reg_read('h08, d); check("R1", "irq ctl", d, 32'h0);
        reg_read('h28, d); check("R1", "empty read queue", d, 32'h0);

        // R2 R3 R4 R8: incrementing write burst
        wq[0] = 8'h11; wq[1] = 8'hC2; wq[2] = 8'h3D; wq[3] = 8'h4E;
        launch(1, 0, 4, 4, 16'h00E4, 0, 0);
        reg_read('h04, d); check("R8", "status while busy", d, 32'h0);
        wait_idle("R8");
        verify("R2_R3_R4", 1, 0, 4, 16'h00E4);
        reg_read('h04, d); check("R8", "status after clean burst", d, 32'h3);

        // R9 completion flag and irq
        reg_read('h08, d); check("R9", "flag set, enable clear", d, 32'h2);
        @(negedge clk); check("R9", "irq masked", 32'(irq), 32'h0);
        reg_write('h08, 32'h1);
        @(negedge clk); check("R9", "irq enabled", 32'(irq), 32'h1);
        reg_write('h08, 32'h3);
        reg_read('h08, d); check("R9", "flag cleared by W1C", d, 32'h1);
        @(negedge clk); check("R9", "irq after clear", 32'(irq), 32'h0);
        reg_write('h08, 32'h0);

        // R3 R4: same-port read burst with waits
        launch(0, 1, 3, 0, 16'h0060, 1, 0);
        wait_idle("R3");
        verify("R3_R4", 0, 1, 3, 16'h0060);
        reg_read('h28, d); check("R4", "drained queue reads zero", d, 32'h0);

        // R5 saturation and zero count
        for (int i = 0; i < 16; i++) wq[i] = 8'($urandom);
        launch(1, 0, 20, 16, 16'h0100, 0, 0);
        wait_idle("R5");
        verify("R5", 1, 0, 16, 16'h0100);
        reg_read('h10, d); check("R5", "count clamps to 16", d, 32'd16);
        launch(0, 0, 0, 0, 16'h0200, 0, 0);
        repeat (20) @(negedge clk);
        check("R5", "zero count starts nothing", nstart, 0);
        reg_read('h04, d); check("R5", "status unchanged by zero count", d, 32'h3);

        // R6 exactly 256 waits completes
        launch(0, 0, 1, 0, 16'h0A0B, 256, 0);
        wait_idle("R6");
        verify("R6", 0, 0, 1, 16'h0A0B);
        reg_read('h04, d); check("R6", "status after 256 waits", d, 32'h3);

        // R7 257 waits aborts read burst
        launch(0, 0, 4, 0, 16'h0070, 300, 0);
        wait_idle("R7");
        reg_read('h04, d); check("R7", "status after timeout", d, 32'h1);
        check("R7", "no cycle after timeout", nstart, 1);
        reg_read('h28, d); check("R7", "read queue emptied", d, 32'h0);
        repeat (80) @(negedge clk);

        // R7 error sync aborts write burst and flushes queued bytes
        wq[0] = 8'hA1; wq[1] = 8'hA2; wq[2] = 8'hA3;
        launch(1, 0, 3, 3, 16'h0080, 0, 1);
        wait_idle("R7");
        reg_read('h04, d); check("R7", "status after error sync", d, 32'h1);
        check("R7", "no cycle after error", nstart, 1);
        wq[0] = 8'h77;
        launch(1, 0, 1, 1, 16'h0081, 0, 0);
        wait_idle("R7");
        verify("R7", 1, 0, 1, 16'h0081);

        // R10 writes during a burst are ignored
        for (int i = 0; i < 8; i++) wq[i] = 8'($urandom);
        launch(1, 0, 8, 8, 16'h0300, 2, 0);
        reg_write('h20, 32'h1234);
        reg_write('h10, 32'h2);
        reg_write('h14, 32'h9);
        reg_write('h00, 32'h1);
        wait_idle("R10");
        repeat (30) @(negedge clk);
        check("R10", "no extra burst", nstart, 8);
        verify("R10", 1, 0, 8, 16'h0300);
        reg_read('h20, d); check("R10", "port unchanged", d, 32'h0300);
        reg_read('h10, d); check("R10", "count unchanged", d, 32'h8);
        reg_read('h14, d); check("R10", "command unchanged", d, 32'h1);

        // random bursts: R2 R3 R4 R6
        for (int t = 0; t < 12; t++) begin
            bit rw, rs;
            int rc, rwt;
            logic [15:0] ra;
            rw = 1'($urandom); rs = 1'($urandom);
            rc = 1 + int'($urandom % 16); rwt = int'($urandom % 4);
            ra = 16'($urandom);
            for (int i = 0; i < 16; i++) wq[i] = 8'($urandom);
            launch(rw, rs, rc, rw ? rc : 0, ra, rwt, 0);
            wait_idle("R2");
            verify("R2_R3_R4_R6", rw, rs, rc, ra);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule